// File: doc/BRIEF.md
# Byte-Lane Decoded Parallel Output Port

This block is a write-only parallel output port that sits on an I/O-mapped bus with a 16-bit data path. It watches the low byte of the address bus together with an active-low write strobe. When a write hits its address, it captures bus data into two 8-bit holding registers, and those registers drive a 16-bit parallel output toward a peripheral. The I/O space is 256 bytes, so the upper address byte plays no part in the decode.

A single match term is built from the address bits: a bit that is 1 in the port address is used as it is, and a bit that is 0 is inverted. The term is then ANDed with the inverted write strobe. Bytes are mapped big-endian: the even address owns data lines 15..8, and those lines hold the more significant byte.

A parameter selects one of two mappings. In word mode the port answers only at its even base address, and both registers load together. In lane mode, address bit 0 is taken out of the match term and picks the even-address register or the odd-address register on its own. A second parameter sets the polarity of the internal enable. The port behaves the same way with either polarity.

Top module: `par_out_port`

## Requirements
- R1: A high `rst` on a rising clock edge clears `port_q` to 0x0000 at that edge.
- R2: In word mode, a write (`wr_n` low) whose address low byte equals the base (default 0xDE) loads `bus_data` into `port_q` at the next rising edge, with `bus_data[15:8]` going to `port_q[15:8]`. Writing 0x1234 sets exactly bits 12, 9, 5, 4 and 2.
- R3: Address bits 15..8 have no effect on the decode. A write to 0x12DE behaves exactly like a write to 0x00DE.
- R4: While `wr_n` is high, `port_q` holds its value, whatever the address and data are.
- R5: In word mode, a write whose low address byte differs from the base leaves `port_q` unchanged. This includes the odd address 0xDF and the next word 0xE0.
- R6: In lane mode, a write to the even address (0xDE) loads `bus_data[15:8]` into `port_q[15:8]` and leaves `port_q[7:0]` unchanged.
- R7: In lane mode, a write to the odd address (0xDF) loads `bus_data[7:0]` into `port_q[7:0]` and leaves `port_q[15:8]` unchanged.
- R8: When reset and a matching write fall in the same cycle, reset wins and `port_q` becomes 0x0000.
- R9: The enable polarity parameter does not change behaviour at the ports. An active-low enable instance produces the same outputs as an active-high one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address bus; only bits 7..0 are decoded |
| bus_data | input | 16 | Write data bus; bits 15..8 belong to the even address |
| wr_n | input | 1 | Active-low I/O write strobe |
| port_q | output | 16 | Registered parallel output to the peripheral |

## Verification
Reset and a decoded write can fall in the same clock edge. The bench provokes this by driving `rst` high while a matching write to the base address is on the bus. It then judges that the output reads zero afterwards, and not the written data.

In lane mode, two byte lanes share one match term. The bench therefore writes each lane in turn with distinct data and checks that the other lane keeps its earlier byte. A word-mode instance and a lane-mode instance with inverted enable polarity run the same stimulus side by side.

// File: rtl/par_port_pkg.sv
package par_port_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    MAP_WORD = 1'b0,
    MAP_LANE = 1'b1
  } map_mode_e;

endpackage

// File: rtl/par_match_term.sv
// Wide AND over the decoded address field plus the inverted write strobe.
module par_match_term #(
  parameter int           FIELD_W = 8,
  parameter logic [FIELD_W-1:0] MATCH_VAL = '0
) (
  input  logic [FIELD_W-1:0] addr_field,
  input  logic               wr_n,
  output logic               hit
);

  logic [FIELD_W-1:0] term;

  generate
    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
      if (MATCH_VAL[i]) begin : g_true
        assign term[i] = addr_field[i];
      end else begin : g_inv
        assign term[i] = ~addr_field[i];
      end
    end
  endgenerate

  assign hit = (&term) & ~wr_n;

endmodule

// File: rtl/par_lane_steer.sv
// Turns the shared hit into one enable per byte lane, in the chosen polarity.
module par_lane_steer
  import par_port_pkg::*;
#(
  parameter int        LANES      = 2,
  parameter int        SEL_W      = 1,
  parameter map_mode_e MODE       = MAP_WORD,
  parameter bit        EN_ACT_LOW = 1'b0
) (
  input  logic             hit,
  input  logic [SEL_W-1:0] lane_sel,
  output logic [LANES-1:0] lane_en
);

  logic [LANES-1:0] lane_hit;

  generate
    if (MODE == MAP_WORD) begin : g_word
      logic sel_unused;
      assign sel_unused = ^lane_sel;
      assign lane_hit   = {LANES{hit}};
    end else begin : g_lane
      for (genvar k = 0; k < LANES; k++) begin : g_sel
        assign lane_hit[k] = hit & (lane_sel == SEL_W'(k));
      end
    end

    if (EN_ACT_LOW) begin : g_low
      assign lane_en = ~lane_hit;
    end else begin : g_high
      assign lane_en = lane_hit;
    end
  endgenerate

endmodule

// File: rtl/par_byte_hold.sv
// Byte holding registers; lane 0 (even address) drives the top byte.
module par_byte_hold
  import par_port_pkg::*;
#(
  parameter int LANES      = 2,
  parameter bit EN_ACT_LOW = 1'b0,
  localparam int DATA_W    = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_q
);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int HI = DATA_W - 1 - k * BYTE_W;
      logic              load;
      logic [BYTE_W-1:0] byte_q;

      assign load = EN_ACT_LOW ? ~lane_en[k] : lane_en[k];

      always_ff @(posedge clk) begin
        if (rst) begin
          byte_q <= '0;
        end else if (load) begin
          byte_q <= data_in[HI -: BYTE_W];
        end
      end

      assign data_q[HI -: BYTE_W] = byte_q;
    end
  endgenerate

endmodule

// File: rtl/par_out_port.sv
module par_out_port
  import par_port_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 16,
  parameter int                DEC_W      = 8,
  parameter logic [DEC_W-1:0]  PORT_BASE  = 8'hDE,
  parameter map_mode_e         MODE       = MAP_WORD,
  parameter bit                EN_ACT_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              wr_n,
  output logic [DATA_W-1:0] port_q
);

  localparam int LANES   = DATA_W / BYTE_W;
  localparam int SEL_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int FIELD_LO = (MODE == MAP_LANE) ? SEL_W : 0;
  localparam int FIELD_W = DEC_W - FIELD_LO;
  localparam logic [FIELD_W-1:0] FIELD_VAL = PORT_BASE[DEC_W-1:FIELD_LO];

  logic             addr_unused;
  logic             hit;
  logic [LANES-1:0] lane_en;

  assign addr_unused = ^bus_addr[ADDR_W-1:DEC_W];

  par_match_term #(
    .FIELD_W   (FIELD_W),
    .MATCH_VAL (FIELD_VAL)
  ) u_match (
    .addr_field (bus_addr[DEC_W-1:FIELD_LO]),
    .wr_n       (wr_n),
    .hit        (hit)
  );

  par_lane_steer #(
    .LANES      (LANES),
    .SEL_W      (SEL_W),
    .MODE       (MODE),
    .EN_ACT_LOW (EN_ACT_LOW)
  ) u_steer (
    .hit      (hit),
    .lane_sel (bus_addr[SEL_W-1:0]),
    .lane_en  (lane_en)
  );

  par_byte_hold #(
    .LANES      (LANES),
    .EN_ACT_LOW (EN_ACT_LOW)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .lane_en (lane_en),
    .data_in (bus_data),
    .data_q  (port_q)
  );

endmodule

// File: rtl/par_out_port_chk.sv
module par_out_port_chk
  import par_port_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               DATA_W    = 16,
  parameter int               DEC_W     = 8,
  parameter logic [DEC_W-1:0] PORT_BASE = 8'hDE,
  parameter map_mode_e        MODE      = MAP_WORD
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              wr_n,
  input logic [DATA_W-1:0] port_q
);

  localparam int HALF = DATA_W / 2;

  logic chk_unused;
  logic low_hit;
  logic hi_hit;

  assign chk_unused = ^bus_addr[ADDR_W-1:DEC_W];
  assign low_hit    = (bus_addr[DEC_W-1:0] == PORT_BASE);
  assign hi_hit     = (bus_addr[DEC_W-1:1] == PORT_BASE[DEC_W-1:1]);

  // R1 and R8: reset clears the output whatever the bus holds
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (port_q == '0));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    wr_n |=> $stable(port_q));

  generate
    if (MODE == MAP_WORD) begin : g_word
      assert_word_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && low_hit) |=> (port_q == $past(bus_data)));

      assert_word_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !low_hit) |=> $stable(port_q));
    end else begin : g_lane
      assert_even_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && hi_hit && !bus_addr[0]) |=>
          (port_q[DATA_W-1:HALF] == $past(bus_data[DATA_W-1:HALF])) &&
          $stable(port_q[HALF-1:0]));

      assert_odd_lane_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && hi_hit && bus_addr[0]) |=>
          (port_q[HALF-1:0] == $past(bus_data[HALF-1:0])) &&
          $stable(port_q[DATA_W-1:HALF]));

      assert_lane_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !hi_hit) |=> $stable(port_q));
    end
  endgenerate

endmodule

bind par_out_port par_out_port_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .DEC_W     (DEC_W),
  .PORT_BASE (PORT_BASE),
  .MODE      (MODE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_data (bus_data),
  .wr_n     (wr_n),
  .port_q   (port_q)
);

// File: tb/test_par_out_port.sv
`timescale 1ns/1ps
module test_par_out_port;
  import par_port_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic [15:0] bus_data;
  logic        wr_n;
  logic [15:0] q_word;
  logic [15:0] q_lane;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  // word mode, active-high enable
  par_out_port #(.MODE(MAP_WORD), .EN_ACT_LOW(1'b0)) i_par_out_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .wr_n(wr_n), .port_q(q_word));

  // lane mode, active-low enable (R9)
  par_out_port #(.MODE(MAP_LANE), .EN_ACT_LOW(1'b1)) i_par_out_port_lane (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .wr_n(wr_n), .port_q(q_lane));

  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] data;
    logic        wn;
    logic [15:0] exp_w;
    logic [15:0] exp_l;
    logic [3:0]  req_w;
    logic [3:0]  req_l;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h00DE, 16'h1234, 1'b0, 16'h1234, 16'h1200, 4'd2, 4'd6},
    '{16'h00DF, 16'hABCD, 1'b0, 16'h1234, 16'h12CD, 4'd5, 4'd7},
    '{16'h00E0, 16'hFFFF, 1'b0, 16'h1234, 16'h12CD, 4'd5, 4'd5},
    '{16'h12DE, 16'h5678, 1'b1, 16'h1234, 16'h12CD, 4'd4, 4'd4},
    '{16'h12DE, 16'h5678, 1'b0, 16'h5678, 16'h56CD, 4'd3, 4'd3},
    '{16'h00DC, 16'h0000, 1'b0, 16'h5678, 16'h56CD, 4'd5, 4'd5},
    '{16'hFFDF, 16'h00EE, 1'b0, 16'h5678, 16'h56EE, 4'd5, 4'd7},
    '{16'h00DE, 16'h0000, 1'b0, 16'h0000, 16'h00EE, 4'd2, 4'd6},
    '{16'h005E, 16'hFFFF, 1'b0, 16'h0000, 16'h00EE, 4'd5, 4'd5},
    '{16'h00DE, 16'h8001, 1'b0, 16'h8001, 16'h80EE, 4'd2, 4'd9}
  };

  function automatic string rname(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string who,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, who, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] d,
                       input logic wn, input logic r);
    @(negedge clk);
    bus_addr = a;
    bus_data = d;
    wr_n     = wn;
    rst      = r;
    @(negedge clk);
    wr_n = 1'b1;
    rst  = 1'b0;
  endtask

  initial begin
    bus_addr = '0;
    bus_data = '0;
    wr_n     = 1'b1;
    rst      = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state on both instances
    check("R1", "word", q_word, 16'h0000);
    check("R1", "lane", q_lane, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].addr, VECS[i].data, VECS[i].wn, 1'b0);
      check(rname(int'(VECS[i].req_w)), "word", q_word, VECS[i].exp_w);
      check(rname(int'(VECS[i].req_l)), "lane", q_lane, VECS[i].exp_l);
    end

    // R2: 0x1234 lights exactly bits 12,9,5,4,2
    drive(16'h00DE, 16'h1234, 1'b0, 1'b0);
    check("R2", "bits", q_word, (16'h1 << 12) | (16'h1 << 9) | (16'h1 << 5)
                                | (16'h1 << 4) | (16'h1 << 2));

    // R4: strobe high with matching address and new data, several cycles
    bus_addr = 16'h00DE;
    bus_data = 16'hFFFF;
    wr_n     = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", "word", q_word, 16'h1234);

    // R8: reset and matching write in the same cycle
    drive(16'h00DE, 16'hBEEF, 1'b0, 1'b1);
    check("R8", "word", q_word, 16'h0000);
    check("R8", "lane", q_lane, 16'h0000);

    // R7 then R6 in lane mode after reset: each lane alone
    drive(16'h00DF, 16'h00A5, 1'b0, 1'b0);
    check("R7", "lane", q_lane, 16'h00A5);
    check("R5", "word", q_word, 16'h0000);
    drive(16'h00DE, 16'h3C00, 1'b0, 1'b0);
    check("R6", "lane", q_lane, 16'h3CA5);
    check("R2", "word", q_word, 16'h3C00);

    // R1: reset clears loaded values
    drive(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R1", "word", q_word, 16'h0000);
    check("R1", "lane", q_lane, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
    end
  end

endmodule